// File: doc/BRIEF.md
# Receive Frame Status Readout Sequencer

This block holds a 32-bit status word for each completed receive frame and hands it to a host one byte at a time. There are two read paths. The host can read a dedicated byte-wide status location. The host can also read the receive data FIFO port, which returns the status after the frame's data has been drained. One position pointer is shared by both paths, so each of the four bytes is delivered exactly once, whichever path reads it. The receive logic upstream supplies a frame-complete strobe together with the byte count, four error flags and two 8-bit event counters. While a status word waits to be consumed, the `frame_busy` output holds the upstream logic off.

A mode input selects how FIFO data reads behave while a status word is pending. In register-direct mode (`fifo_direct`=0), FIFO data reads are refused until the status location has delivered all four bytes. In FIFO-direct mode (`fifo_direct`=1), a FIFO read returns data while data of the current frame remains. Once that data is exhausted, FIFO reads return the remaining status bytes. The FIFO storage is outside the block. It presents its head byte on `fifo_din` and reports whether it still holds data of the current frame. The block pops the storage only on a granted data read.

The byte count comes from the upstream logic. It excludes pad and the 4 FCS bytes when pad stripping is on, and it gives the duration of activity in byte times after a late collision. The host must ignore the count whenever the overflow flag is set.

Top module: `rx_status_sequencer`

## Requirements
- R1: After reset, `frame_busy` is 0. A `frame_done` pulse while `frame_busy` is 0 latches the status inputs, and `frame_busy` reads 1 from the next cycle.
- R2: The status bytes are laid out as follows. Byte 0 is count[7:0]. Byte 1 is {overflow, collision, framing error, FCS error, count[11:8]}, with overflow in bit 7. Byte 2 is the runt counter. Byte 3 is the collision counter.
- R3: Successive status-location reads return byte 0, 1, 2 and 3, in that order, on `stat_rdata` in the cycle after each read strobe. `frame_busy` drops in the cycle after the fourth byte is taken.
- R4: In register-direct mode, a FIFO read while a status word is pending is refused. `fifo_pop` stays 0, `fifo_rdata` reads 0x00, and the status position does not move.
- R5: In FIFO-direct mode, a FIFO read with `fifo_data_avail`=1 pops the storage and returns `fifo_din`. A FIFO read with `fifo_data_avail`=0 and a pending status returns the next status byte.
- R6: The two paths share one position, and each byte is delivered once. When both strobes fall in the same cycle, the status location takes byte k and the FIFO read takes byte k+1. If byte k is the last byte, the FIFO read returns 0x00 and pops nothing.
- R7: A status-location read with no pending status returns 0x00.
- R8: A `frame_done` pulse while `frame_busy` is 1 is ignored. The held status bytes read back unchanged.
- R9: Cycles without read strobes leave the status position unchanged.
- R10: With no status pending, a FIFO read pops and returns `fifo_din` if data is available, in either mode. Otherwise it returns 0x00 with no pop.
- R11: Reset in the middle of a sequence clears the pending status and the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | One-cycle strobe: a receive frame has completed |
| frame_count | input | 12 | Received byte count |
| flag_ovfl | input | 1 | FIFO overflow flag |
| flag_coll | input | 1 | Collision flag |
| flag_fram | input | 1 | Framing error flag |
| flag_fcs | input | 1 | FCS error flag |
| runt_cnt | input | 8 | Runt packet counter value |
| coll_cnt | input | 8 | Receive collision counter value |
| frame_busy | output | 1 | Status pending; upstream must hold off |
| fifo_direct | input | 1 | 1: FIFO-direct mode, 0: register-direct mode |
| stat_rd | input | 1 | Read strobe for the status location |
| stat_rdata | output | 8 | Registered status-location read data |
| fifo_rd | input | 1 | Read strobe for the FIFO data location |
| fifo_data_avail | input | 1 | Storage holds data of the current frame |
| fifo_din | input | 8 | Head byte of the storage |
| fifo_pop | output | 1 | Pop request to the storage |
| fifo_rdata | output | 8 | Registered FIFO-location read data |

## Verification
A status-location read and a FIFO read can fall in the same clock cycle, and both can want a status byte. The bench raises both strobes together in FIFO-direct mode at two points. The first is in the middle of a sequence, where the two paths must return adjacent bytes. The second is at the last byte, where the FIFO read must come back empty and must not pop. The scoreboard queues the byte it expects on each bus and compares both buses in the cycle after the strobes. It then checks that `frame_busy` falls exactly once.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int CNT_W = 12;
  localparam int CTR_W = 8;

  typedef struct packed {
    logic [CTR_W-1:0] coll_ctr;
    logic [CTR_W-1:0] runt_ctr;
    logic             ovfl;
    logic             coll;
    logic             fram;
    logic             fcs;
    logic [CNT_W-1:0] count;
  } rx_stat_t;

  localparam int STAT_W = $bits(rx_stat_t);
endpackage

// File: rtl/rxs_status_store.sv
module rxs_status_store #(
  parameter int DATA_W = 8,
  parameter int NBYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 capture,
  input  rxs_pkg::rx_stat_t    stat_in,
  input  logic [1:0]           advance,
  output logic                 pend,
  output logic [$clog2(NBYTES)-1:0] idx,
  output logic [DATA_W-1:0]    byte_cur,
  output logic [DATA_W-1:0]    byte_nxt
);
  localparam int IDX_W  = $clog2(NBYTES);
  localparam int SUM_W  = IDX_W + 2;
  localparam int WORD_W = DATA_W * NBYTES;

  logic [WORD_W-1:0] word_q;
  logic [DATA_W-1:0] lanes [NBYTES];
  logic [SUM_W-1:0]  idx_sum;
  logic [SUM_W-1:0]  idx_nxt;

  generate
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      assign lanes[g] = word_q[g*DATA_W +: DATA_W];
    end
  endgenerate

  assign idx_sum  = SUM_W'(idx) + SUM_W'(advance);
  assign idx_nxt  = SUM_W'(idx) + SUM_W'(1);
  assign byte_cur = lanes[idx];
  assign byte_nxt = (idx_nxt < SUM_W'(NBYTES)) ? lanes[idx_nxt[IDX_W-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      idx    <= '0;
      word_q <= '0;
    end else if (!pend) begin
      if (capture) begin
        pend   <= 1'b1;
        idx    <= '0;
        word_q <= WORD_W'(stat_in);
      end
    end else if (idx_sum >= SUM_W'(NBYTES)) begin
      pend <= 1'b0;
      idx  <= '0;
    end else begin
      idx <= idx_sum[IDX_W-1:0];
    end
  end

  p_capture_r1: assert property (@(posedge clk) disable iff (rst)
    (capture && !pend) |=> pend);
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (capture && pend) |=> $stable(word_q));
  p_idle_pos_r11: assert property (@(posedge clk) disable iff (rst)
    !pend |-> (idx == '0));
  p_hold_pos_r9: assert property (@(posedge clk) disable iff (rst)
    (pend && advance == 2'd0) |=> (pend && $stable(idx)));
  p_drain_r3: assert property (@(posedge clk) disable iff (rst)
    (pend && idx == IDX_W'(NBYTES-1) && advance != 2'd0) |=> !pend);
endmodule

// File: rtl/rxs_read_arbiter.sv
module rxs_read_arbiter #(
  parameter int NBYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      pend,
  input  logic [$clog2(NBYTES)-1:0] idx,
  input  logic                      stat_rd,
  input  logic                      fifo_rd,
  input  logic                      fifo_direct,
  input  logic                      data_avail,
  output logic                      stat_take,
  output logic                      fifo_take,
  output logic                      fifo_pop,
  output logic [1:0]                advance
);
  localparam int IDX_W = $clog2(NBYTES);

  logic last_byte;
  logic left_after_stat;

  always_comb begin
    last_byte       = (idx == IDX_W'(NBYTES-1));
    stat_take       = stat_rd && pend;
    left_after_stat = pend && !(stat_take && last_byte);
    fifo_pop        = fifo_rd && data_avail && (fifo_direct || !pend);
    fifo_take       = fifo_rd && fifo_direct && !data_avail && left_after_stat;
    advance         = {1'b0, stat_take} + {1'b0, fifo_take};
  end

  p_one_path_r6: assert property (@(posedge clk) disable iff (rst)
    !(fifo_pop && fifo_take));
  p_idle_no_take_r7: assert property (@(posedge clk) disable iff (rst)
    !pend |-> (advance == 2'd0));
endmodule

// File: rtl/rx_status_sequencer.sv
module rx_status_sequencer #(
  parameter int DATA_W = 8,
  parameter int NBYTES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        frame_done,
  input  logic [11:0] frame_count,
  input  logic        flag_ovfl,
  input  logic        flag_coll,
  input  logic        flag_fram,
  input  logic        flag_fcs,
  input  logic [7:0]  runt_cnt,
  input  logic [7:0]  coll_cnt,
  output logic        frame_busy,
  input  logic        fifo_direct,
  input  logic        stat_rd,
  output logic [7:0]  stat_rdata,
  input  logic        fifo_rd,
  input  logic        fifo_data_avail,
  input  logic [7:0]  fifo_din,
  output logic        fifo_pop,
  output logic [7:0]  fifo_rdata
);
  localparam int IDX_W = $clog2(NBYTES);

  rxs_pkg::rx_stat_t   stat_in;
  logic                pend;
  logic [IDX_W-1:0]    idx;
  logic [DATA_W-1:0]   byte_cur;
  logic [DATA_W-1:0]   byte_nxt;
  logic                stat_take;
  logic                fifo_take;
  logic [1:0]          advance;

  always_comb begin
    stat_in.count    = frame_count;
    stat_in.ovfl     = flag_ovfl;
    stat_in.coll     = flag_coll;
    stat_in.fram     = flag_fram;
    stat_in.fcs      = flag_fcs;
    stat_in.runt_ctr = runt_cnt;
    stat_in.coll_ctr = coll_cnt;
  end

  rxs_status_store #(.DATA_W(DATA_W), .NBYTES(NBYTES)) u_store (
    .clk(clk), .rst(rst), .capture(frame_done), .stat_in(stat_in),
    .advance(advance), .pend(pend), .idx(idx),
    .byte_cur(byte_cur), .byte_nxt(byte_nxt)
  );

  rxs_read_arbiter #(.NBYTES(NBYTES)) u_arb (
    .clk(clk), .rst(rst), .pend(pend), .idx(idx),
    .stat_rd(stat_rd), .fifo_rd(fifo_rd), .fifo_direct(fifo_direct),
    .data_avail(fifo_data_avail), .stat_take(stat_take),
    .fifo_take(fifo_take), .fifo_pop(fifo_pop), .advance(advance)
  );

  assign frame_busy = pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_rdata <= '0;
      fifo_rdata <= '0;
    end else begin
      stat_rdata <= stat_take ? byte_cur : '0;
      if (fifo_pop)
        fifo_rdata <= fifo_din;
      else if (fifo_take)
        fifo_rdata <= stat_take ? byte_nxt : byte_cur;
      else
        fifo_rdata <= '0;
    end
  end

  p_refuse_r4: assert property (@(posedge clk) disable iff (rst)
    (fifo_rd && !fifo_direct && frame_busy) |-> !fifo_pop);
  p_refuse_data_r4: assert property (@(posedge clk) disable iff (rst)
    (fifo_rd && !fifo_direct && frame_busy) |=> (fifo_rdata == 8'h00));
  p_idle_stat_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !frame_busy) |=> (stat_rdata == 8'h00));
  p_data_pass_r5: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> (fifo_rdata == $past(fifo_din)));
endmodule

// File: tb/rx_status_sequencer_bench.sv
module rx_status_sequencer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_done = 1'b0;
  logic [11:0] frame_count = '0;
  logic flag_ovfl = 1'b0, flag_coll = 1'b0, flag_fram = 1'b0, flag_fcs = 1'b0;
  logic [7:0] runt_cnt = '0, coll_cnt = '0;
  logic frame_busy;
  logic fifo_direct = 1'b0;
  logic stat_rd = 1'b0;
  logic [7:0] stat_rdata;
  logic fifo_rd = 1'b0;
  logic fifo_data_avail = 1'b0;
  logic [7:0] fifo_din = '0;
  logic fifo_pop;
  logic [7:0] fifo_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    int         sig;
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  rx_status_sequencer u_rx_status_sequencer (
    .clk(clk), .rst(rst), .frame_done(frame_done), .frame_count(frame_count),
    .flag_ovfl(flag_ovfl), .flag_coll(flag_coll), .flag_fram(flag_fram),
    .flag_fcs(flag_fcs), .runt_cnt(runt_cnt), .coll_cnt(coll_cnt),
    .frame_busy(frame_busy), .fifo_direct(fifo_direct), .stat_rd(stat_rd),
    .stat_rdata(stat_rdata), .fifo_rd(fifo_rd),
    .fifo_data_avail(fifo_data_avail), .fifo_din(fifo_din),
    .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares queued expectations in the cycle after they were driven.
  initial begin
    forever begin
      int n;
      @(posedge clk);
      n = sb.size();
      @(negedge clk);
      for (int i = 0; i < n; i++) begin
        exp_t e;
        e = sb.pop_front();
        case (e.sig)
          0:       check({e.tag, " stat_rdata"}, stat_rdata, e.val);
          1:       check({e.tag, " fifo_rdata"}, fifo_rdata, e.val);
          default: check({e.tag, " frame_busy"}, {7'd0, frame_busy}, e.val);
        endcase
      end
    end
  end

  function automatic logic [7:0] lane(input int k, input logic [11:0] c,
      input logic [3:0] f, input logic [7:0] r, input logic [7:0] cc);
    case (k)
      0:       return c[7:0];
      1:       return {f, c[11:8]};
      2:       return r;
      default: return cc;
    endcase
  endfunction

  task automatic push(input int sig, input logic [7:0] v, input string tag);
    exp_t e;
    e.sig = sig; e.val = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic busy_is(input logic b, input string tag);
    @(negedge clk);
    push(2, {7'd0, b}, tag);
  endtask

  task automatic send_frame(input logic [11:0] c, input logic [3:0] f,
      input logic [7:0] r, input logic [7:0] cc);
    @(negedge clk);
    frame_done = 1'b1; frame_count = c;
    {flag_ovfl, flag_coll, flag_fram, flag_fcs} = f;
    runt_cnt = r; coll_cnt = cc;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  // Driver: one read cycle, pushes what each read bus must show next cycle.
  task automatic rd(input logic s, input logic f, input logic da, input logic [7:0] din,
      input logic [7:0] es, input logic [7:0] ef, input logic ep, input string tag);
    @(negedge clk);
    stat_rd = s; fifo_rd = f; fifo_data_avail = da; fifo_din = din;
    #1;
    check({tag, " fifo_pop"}, {7'd0, fifo_pop}, {7'd0, ep});
    if (s) push(0, es, tag);
    if (f) push(1, ef, tag);
    @(negedge clk);
    stat_rd = 1'b0; fifo_rd = 1'b0; fifo_data_avail = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] c;
    logic [3:0]  f;
    logic [7:0]  r, cc;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    busy_is(1'b0, "R1 reset state");
    rd(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, "R7 idle status read");

    c = 12'hABC; f = 4'b1010; r = 8'h11; cc = 8'h22;
    send_frame(c, f, r, cc);
    busy_is(1'b1, "R1 capture");
    send_frame(12'h123, 4'b0101, 8'h77, 8'h88);   // R8: ignored while busy
    repeat (5) @(negedge clk);                    // R9: idle cycles
    fifo_direct = 1'b0;
    rd(1'b0, 1'b1, 1'b1, 8'h5A, 8'h00, 8'h00, 1'b0, "R4 refused read");
    for (int k = 0; k < 4; k++)
      rd(1'b1, 1'b0, 1'b0, 8'h00, lane(k, c, f, r, cc), 8'h00, 1'b0, "R2 R3 R8 R9 byte order");
    busy_is(1'b0, "R3 drained");
    rd(1'b0, 1'b1, 1'b1, 8'h3C, 8'h00, 8'h3C, 1'b1, "R10 data read idle");

    fifo_direct = 1'b1;
    c = 12'h5F0; f = 4'b0001; r = 8'h33; cc = 8'h44;
    send_frame(c, f, r, cc);
    rd(1'b0, 1'b1, 1'b1, 8'hC3, 8'h00, 8'hC3, 1'b1, "R5 data pop");
    rd(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, lane(0, c, f, r, cc), 1'b0, "R5 status via fifo");
    rd(1'b1, 1'b0, 1'b0, 8'h00, lane(1, c, f, r, cc), 8'h00, 1'b0, "R6 mixed path");
    rd(1'b1, 1'b1, 1'b0, 8'h00, lane(2, c, f, r, cc), lane(3, c, f, r, cc), 1'b0, "R6 same cycle");
    busy_is(1'b0, "R6 drained once");

    c = 12'h801; f = 4'b1100; r = 8'h55; cc = 8'h66;
    send_frame(c, f, r, cc);
    for (int k = 0; k < 3; k++)
      rd(1'b1, 1'b0, 1'b0, 8'h00, lane(k, c, f, r, cc), 8'h00, 1'b0, "R3 second frame");
    rd(1'b1, 1'b1, 1'b0, 8'h00, lane(3, c, f, r, cc), 8'h00, 1'b0, "R6 last byte collision");
    busy_is(1'b0, "R6 last byte drained");
    rd(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, "R10 empty fifo");

    send_frame(12'h0FF, 4'b0000, 8'h01, 8'h02);
    rd(1'b1, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h00, 1'b0, "R3 before reset");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    busy_is(1'b0, "R11 reset clears");
    rd(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, "R11 R7 no status after reset");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule